// File: doc/BRIEF.md
# I2C Register Port Slave

This block is a slave on a two-wire I2C bus that lets a bus master read and write a small bank of byte-wide registers held next to it. A fast system clock oversamples SCL and SDA. The slave finds START and STOP conditions, matches its 7-bit device address and acknowledges it. In a write it takes the first data byte as a register pointer and stores every later byte at that pointer. In a read it streams bytes out from the pointer. After each byte moved the pointer advances by one, and it wraps around the end of the bank.

The register bank itself sits outside the block. It is reached through a synchronous port: an index that always shows the current pointer, a one-cycle write strobe with its data byte, and a one-cycle read strobe. Read data must appear combinationally on the read-data input for the index shown. The slave drives SDA through an open-drain pull-down enable, so the line is driven only low or left released. It never drives SCL.

Top module: `i2cs_port`

## Requirements
- R1: After synchronous reset, SDA is released (`sda_pull` = 0), neither strobe is active and the pointer (`reg_idx`) is 0.
- R2: A STOP (SDA rising while SCL is high) returns the slave to idle. Bytes clocked after a STOP and before a new START are neither acknowledged nor stored.
- R3: The first byte after a START is compared against device address 7'h68 in bits 7..1; bit 0 selects read (1) or write (0), so 8'hD0 writes and 8'hD1 reads. On any other address the slave gives no acknowledge and ignores the bus, storing nothing, until the next START.
- R4: Bytes travel MSB first. The slave pulls SDA low during the ninth clock after a matching address byte (in both directions), after the word-address byte and after every written data byte.
- R5: In a write, bits 2..0 of the first byte after the address are loaded into the pointer. Each later byte gives exactly one single-cycle `reg_wr` pulse with that byte at the current pointer, and the pointer then increments. `reg_wr` and `reg_rd` are never active together.
- R6: The pointer is 3 bits wide and steps from 7 back to 0.
- R7: In a read, the byte at the pointer is sent MSB first. The pointer increments only when the master acknowledges (SDA low on the ninth clock). After a NACK the slave releases SDA and stays silent, so further clocked bits read as 1, until the next START.
- R8: A repeated START that follows the pointer write, with address 8'hD1, switches to reading from the pointer just loaded.
- R9: A read that follows START plus 8'hD1 directly, with no pointer write, begins at the pointer left by the previous access.
- R10: SDA is changed by the slave only while SCL is low, and a START leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_idx | output | 3 | Current register pointer, used as the bank index |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wbyte | output | 8 | Byte to store at `reg_idx` while `reg_wr` is high |
| reg_rd | output | 1 | One-cycle strobe when a byte is fetched for sending |
| reg_rbyte | input | 8 | Bank contents at `reg_idx`, combinational |

## Verification
Every 7-bit address other than the device's own is tried, so any decode bit that is wrong shows up as a stray acknowledge. Clocking a byte after a STOP tells STOP handling apart from address matching. For each of the eight start pointers, a nine-byte write burst followed by an eight-byte read-back separates correct wrap-around from one-off pointer errors, because the first register is overwritten at the end of the burst. Ending each read with a NACK and then one extra clocked byte checks that the pointer counts acknowledges and not bytes sent, and that the slave lets go of the line. A bare read at the end checks that the pointer survives between transfers.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [6:0] DEF_DEV_ADDR = 7'h68;
    localparam int         BYTE_W       = 8;
    localparam int         SYNC_STAGES  = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK_W,
        ST_AACK_R,
        ST_WORD,
        ST_WACK,
        ST_WDATA,
        ST_DACK,
        ST_LOAD,
        ST_TX,
        ST_RACK,
        ST_SKIP
    } slv_state_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

    function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic [STAGES-1:0] pipe;
        logic              last;

        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '1;
                last <= 1'b1;
            end else begin
                pipe <= {pipe[STAGES-2:0], din[i]};
                last <= pipe[STAGES-1];
            end
        end

        assign lvl[i]  = pipe[STAGES-1];
        assign rise[i] = pipe[STAGES-1] & ~last;
        assign fall[i] = ~pipe[STAGES-1] & last;
    end
endmodule

// File: rtl/i2cs_ptr.sv
module i2cs_ptr import i2cs_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= PTR_W'(ring_next(32'(ptr), DEPTH));
        end
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine import i2cs_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR,
    parameter int         PTR_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_q,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [BYTE_W-1:0] rbyte,
    output logic              sda_pull,
    output logic              start_det,
    output logic              wr_strobe,
    output logic [BYTE_W-1:0] wbyte,
    output logic              rd_strobe,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_load_val,
    output logic              ptr_step
);
    localparam logic [3:0] BITS = 4'(BYTE_W);

    slv_state_t        st;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        cnt;
    logic              mack;
    logic              wr_q;
    logic              stop_det;
    logic              byte_end;

    assign start_det = sda_fall & scl_q;
    assign stop_det  = sda_rise & scl_q;
    assign byte_end  = scl_fall && (cnt == BITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            shreg <= '0;
            cnt   <= '0;
            mack  <= 1'b0;
            wr_q  <= 1'b0;
            wbyte <= '0;
        end else begin
            wr_q <= 1'b0;
            if (start_det) begin
                st  <= ST_ADDR;
                cnt <= '0;
            end else if (stop_det) begin
                st <= ST_IDLE;
            end else begin
                unique case (st)
                    ST_ADDR, ST_WORD, ST_WDATA: begin
                        if (scl_rise && cnt != BITS) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_q};
                            cnt   <= cnt + 4'd1;
                        end
                        if (byte_end) begin
                            cnt <= '0;
                            if (st == ST_ADDR) begin
                                if (addr_hit(shreg, DEV_ADDR))
                                    st <= shreg[0] ? ST_AACK_R : ST_AACK_W;
                                else
                                    st <= ST_SKIP;
                            end else if (st == ST_WORD) begin
                                st <= ST_WACK;
                            end else begin
                                st    <= ST_DACK;
                                wr_q  <= 1'b1;
                                wbyte <= shreg;
                            end
                        end
                    end
                    ST_AACK_W: if (scl_fall) st <= ST_WORD;
                    ST_AACK_R: if (scl_fall) st <= ST_LOAD;
                    ST_WACK, ST_DACK: if (scl_fall) st <= ST_WDATA;
                    ST_LOAD: begin
                        shreg <= rbyte;
                        cnt   <= '0;
                        st    <= ST_TX;
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b1};
                            cnt   <= cnt + 4'd1;
                            if (cnt == BITS - 4'd1) st <= ST_RACK;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack <= ~sda_q;
                        if (scl_fall) st <= mack ? ST_LOAD : ST_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (st)
            ST_AACK_W, ST_AACK_R, ST_WACK, ST_DACK: sda_pull = 1'b1;
            ST_TX:                                  sda_pull = ~shreg[BYTE_W-1];
            default:                                sda_pull = 1'b0;
        endcase
    end

    assign wr_strobe    = wr_q;
    assign rd_strobe    = (st == ST_LOAD);
    assign ptr_load     = (st == ST_WORD) && byte_end;
    assign ptr_load_val = shreg[PTR_W-1:0];
    assign ptr_step     = wr_q || ((st == ST_RACK) && scl_fall && mack);
endmodule

// File: rtl/i2cs_port.sv
module i2cs_port import i2cs_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR,
    parameter int         DEPTH    = 8,
    localparam int        PTR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [PTR_W-1:0]  reg_idx,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wbyte,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rbyte
);
    logic [1:0]       lvl, rise, fall;
    logic             scl_q, start_q;
    logic             ptr_load, ptr_step;
    logic [PTR_W-1:0] ptr_load_val;

    i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sda_in, scl_in}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign scl_q = lvl[0];

    i2cs_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .scl_q        (scl_q),
        .scl_rise     (rise[0]),
        .scl_fall     (fall[0]),
        .sda_q        (lvl[1]),
        .sda_rise     (rise[1]),
        .sda_fall     (fall[1]),
        .rbyte        (reg_rbyte),
        .sda_pull     (sda_pull),
        .start_det    (start_q),
        .wr_strobe    (reg_wr),
        .wbyte        (reg_wbyte),
        .rd_strobe    (reg_rd),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_step     (ptr_step)
    );

    i2cs_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .step     (ptr_step),
        .ptr      (reg_idx)
    );
endmodule

// File: rtl/i2cs_port_chk.sv
module i2cs_port_chk #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_q,
    input logic             start_q,
    input logic             sda_pull,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [PTR_W-1:0] reg_idx
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    // R10
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> !scl_q);

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !sda_pull);

    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // R6
    ptr_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_idx == (($past(reg_idx) == LAST) ? '0 : $past(reg_idx) + 1'b1)));
endmodule

bind i2cs_port i2cs_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_q    (scl_q),
    .start_q  (start_q),
    .sda_pull (sda_pull),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_idx  (reg_idx)
);

// File: tb/i2cs_port_bench.sv
module i2cs_port_bench;
    localparam int DEPTH = 8;
    localparam int PW    = 3;
    localparam int Q     = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_bus;
    logic          sda_pull;
    logic [PW-1:0] reg_idx;
    logic          reg_wr, reg_rd;
    logic [7:0]    reg_wbyte, reg_rbyte;

    logic [7:0] mem [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    int         wr_cnt = 0;
    int         viol = 0;
    logic       prev_pull = 1'b0;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_pull;
    assign reg_rbyte = mem[reg_idx];

    i2cs_port u_i2cs_port (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl),
        .sda_in    (sda_bus),
        .sda_pull  (sda_pull),
        .reg_idx   (reg_idx),
        .reg_wr    (reg_wr),
        .reg_wbyte (reg_wbyte),
        .reg_rd    (reg_rd),
        .reg_rbyte (reg_rbyte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (reg_wr) begin
            mem[reg_idx] <= reg_wbyte;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // R10 monitor: the pull-down may only change while raw SCL is low
    always @(negedge clk) begin
        if (!rst && sda_pull != prev_pull && scl) viol++;
        prev_pull <= sda_pull;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        acked = ~sda_bus;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_bus;
            tick(Q);
            scl = 1'b0;
        end
        tick(Q);
        sda_m = ~give_ack; tick(Q);
        scl = 1'b1;        tick(2 * Q);
        scl = 1'b0;        tick(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] pattern(input int p, input int k);
        return 8'(p * 53 + k * 29 + 7);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        bit         ack;
        int         nacks;
        int         wr_base;
        logic [7:0] rb;

        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(4);

        // R1 reset state
        check("R1 sda_pull after reset", int'(sda_pull), 0);
        check("R1 reg_wr after reset", int'(reg_wr), 0);
        check("R1 reg_rd after reset", int'(reg_rd), 0);
        check("R1 pointer after reset", int'(reg_idx), 0);

        // R3 every foreign address is left unacknowledged
        for (int a = 0; a < 128; a++) begin
            if (a == 'h68) continue;
            bus_start();
            write_byte({7'(a), 1'b0}, ack);
            check($sformatf("R3 ack for address %0d", a), int'(ack), 0);
            bus_stop();
        end
        bus_start();
        write_byte(8'hA4, ack);
        write_byte(8'h33, ack);
        check("R3 byte after foreign address acked", int'(ack), 0);
        write_byte(8'h5C, ack);
        bus_stop();
        check("R3 writes after foreign address", wr_cnt, 0);
        check("R3 pointer after foreign address", int'(reg_idx), 0);

        // R2 bytes after STOP with no START are ignored
        scl = 1'b0; tick(Q);
        write_byte(8'hD0, ack);
        check("R2 ack after STOP", int'(ack), 0);
        write_byte(8'h05, ack);
        check("R2 second byte ack after STOP", int'(ack), 0);
        write_byte(8'h77, ack);
        check("R2 writes after STOP", wr_cnt, 0);

        // R4 R5 R6 R7 R8 sweep over all start pointers
        for (int p = 0; p < DEPTH; p++) begin
            wr_base = wr_cnt;
            nacks = 0;
            bus_start();
            write_byte(8'hD0, ack);
            check("R4 write address ack", int'(ack), 1);
            write_byte(8'(p) | 8'hF8, ack);
            check("R4 word address ack", int'(ack), 1);
            for (int k = 0; k <= DEPTH; k++) begin
                write_byte(pattern(p, k), ack);
                if (!ack) nacks++;
                exp_mem[(p + k) % DEPTH] = pattern(p, k);
            end
            check("R4 data byte nacks", nacks, 0);
            bus_stop();
            check("R5 write strobes per burst", wr_cnt - wr_base, DEPTH + 1);
            check("R6 pointer after wrapping burst", int'(reg_idx), (p + DEPTH + 1) % DEPTH);

            bus_start();
            write_byte(8'hD0, ack);
            write_byte(8'(p), ack);
            bus_rstart();
            write_byte(8'hD1, ack);
            check("R8 read address ack after repeated START", int'(ack), 1);
            for (int k = 0; k < DEPTH; k++) begin
                read_byte(k < DEPTH - 1, rb);
                check($sformatf("R8 R7 read p=%0d k=%0d", p, k), int'(rb),
                      int'(exp_mem[(p + k) % DEPTH]));
            end
            tick(2);
            check("R7 SDA released after NACK", int'(sda_pull), 0);
            read_byte(1'b0, rb);
            check("R7 silent after NACK", int'(rb), 'hFF);
            bus_stop();
            check("R7 pointer counts master acks", int'(reg_idx), (p + DEPTH - 1) % DEPTH);
            check("R5 no strobe during read", wr_cnt - wr_base, DEPTH + 1);
        end

        // R9 read without pointer write continues from the stored pointer (6)
        bus_start();
        write_byte(8'hD1, ack);
        check("R9 read address ack", int'(ack), 1);
        read_byte(1'b1, rb);
        check("R9 first byte from stored pointer", int'(rb), int'(exp_mem[6]));
        read_byte(1'b0, rb);
        check("R9 second byte", int'(rb), int'(exp_mem[7]));
        bus_stop();
        check("R9 pointer after short read", int'(reg_idx), 7);

        // R10 line discipline
        check("R10 SDA changes while SCL high", viol, 0);

        summary();
        $finish;
    end
endmodule